// File: doc/BRIEF.md
# SPI Master Shift Engine with Low-Power Freeze

This block is the master side of a single-byte SPI exchange. A one-cycle start strobe takes a byte and launches a transfer. The engine makes SCK from a programmable baud divider. It shifts the byte out on MOSI, most significant bit first, and gathers the byte coming back on MISO. When the byte is complete it raises a one-cycle done flag. It runs in SPI mode 0: SCK idles low, MISO is sampled on the rising edge, and MOSI moves on the falling edge. An optional chip-select output can be driven low by the engine for the length of the transfer.

Power management works through one internal clock enable. A stop request always drops the enable. A wait request drops it only when the wait-freeze control is set. While the enable is low, every piece of transfer state holds its value: the divider count, the SCK level, the shift registers and the chip-select. When the request is released, the exchange resumes from the same point. No bit is lost and no half-period is cut short.

Top module: `spi_freeze_master`

## Requirements
- R1: SCK is 0 whenever busy is 0. While busy, MOSI changes only in the cycle in which SCK falls, and bits leave on MOSI most significant bit first.
- R2: Each SCK half-period lasts exactly cfg_div+1 clock cycles with the enable active. The divider value is captured when a start is accepted.
- R3: While busy, a stop request, or a wait request with cfg_wait_dis=1, freezes the transfer. SCK, MOSI, ss_n and the divider hold their values for as long as the request lasts.
- R4: With cfg_wait_dis=0, wait_req has no effect on SCK timing or on the data exchanged.
- R5: stop_req freezes the transfer whatever the value of cfg_wait_dis.
- R6: After any pattern of freezes, the byte sent on MOSI equals tx_byte, and rx_byte equals the eight MISO bits sampled on the rising SCK edges, first sample in bit 7.
- R7: With cfg_ssoe=1, ss_n goes low in the cycle after a start is accepted, which is at least one half-period before the first SCK rise. It returns high one half-period after the last SCK fall.
- R8: With cfg_ssoe=0, ss_n stays 1 at all times.
- R9: rx_done is high for exactly one cycle per transfer, and rx_byte holds the received byte in that cycle.
- R10: A start strobe is ignored while busy=1 or while frozen (the enable is low, even when idle).
- R11: After reset, sck=0, mosi=0, ss_n=1, busy=0 and rx_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle strobe that begins a transfer of tx_byte |
| tx_byte | input | DATA_W | Byte to send, captured on an accepted start |
| cfg_div | input | DIV_W | SCK half-period minus one, in enabled clock cycles |
| cfg_ssoe | input | 1 | 1: engine drives ss_n low during a transfer |
| cfg_wait_dis | input | 1 | 1: wait_req freezes the engine |
| stop_req | input | 1 | Stop request; always freezes |
| wait_req | input | 1 | Wait request; freezes only if cfg_wait_dis=1 |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| frozen | output | 1 | Busy with the internal enable low |
| rx_byte | output | DATA_W | Last received byte |
| rx_done | output | 1 | One-cycle pulse when rx_byte is updated |

## Verification
The properties assume that cfg_ssoe, cfg_wait_dis and cfg_div change only while busy is low. They also assume that start is a single-cycle strobe. The bench writes the configuration only between transfers, when it has seen busy low. Its random stop and wait toggling during a transfer touches only the request inputs, never the configuration. The bench's slave model changes MISO only after SCK falls, so MISO is stable at every rising edge the engine samples.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } spi_st_e;
endpackage

// File: rtl/spi_pm_gate.sv
module spi_pm_gate (
  input  logic stop_req,
  input  logic wait_req,
  input  logic wait_dis,
  output logic ce
);
  logic hold_w;
  always_comb begin
    hold_w = stop_req | (wait_req & wait_dis);
    ce     = ~hold_w;
  end
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_d = div_q;
    if (load) div_d = div_in;
    cnt_d = cnt_q;
    if (ce) begin
      if (!run || (cnt_q == div_q)) cnt_d = '0;
      else                          cnt_d = cnt_q + 1'b1;
    end
    tick = run & (cnt_q == div_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ssoe,
  input  logic              miso,
  output logic              accept,
  output logic              run,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_done
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int HC_W   = $clog2(EDGES + 1);
  localparam logic [HC_W-1:0] LAST_RISE = HC_W'(EDGES - 2);
  localparam logic [HC_W-1:0] LAST_FALL = HC_W'(EDGES - 1);

  spi_st_e           st_q, st_d;
  logic [HC_W-1:0]   half_q, half_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              sck_q, sck_d;
  logic              ss_q, ss_d;
  logic              done_q, done_d;
  logic              step;

  always_comb begin
    accept = (st_q == ST_IDLE) & start & ce;
    step   = ce & tick;
    st_d   = st_q;
    half_d = half_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    out_d  = out_q;
    sck_d  = sck_q;
    ss_d   = ss_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_LEAD;
          tx_d   = tx_byte;
          ss_d   = ~ssoe;
          half_d = '0;
        end
      end
      ST_LEAD: begin
        if (step) begin
          st_d   = ST_SHIFT;
          sck_d  = 1'b1;
          rx_d   = {rx_q[DATA_W-2:0], miso};
          half_d = half_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (step) begin
          half_d = half_q + 1'b1;
          if (sck_q) begin
            sck_d = 1'b0;
            tx_d  = {tx_q[DATA_W-2:0], 1'b0};
            if (half_q == LAST_FALL) st_d = ST_TRAIL;
          end else begin
            sck_d = 1'b1;
            rx_d  = {rx_q[DATA_W-2:0], miso};
            if (half_q == LAST_RISE) begin
              out_d  = {rx_q[DATA_W-2:0], miso};
              done_d = 1'b1;
            end
          end
        end
      end
      ST_TRAIL: begin
        if (step) begin
          st_d = ST_IDLE;
          ss_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      out_q  <= '0;
      sck_q  <= 1'b0;
      ss_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      half_q <= half_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      out_q  <= out_d;
      sck_q  <= sck_d;
      ss_q   <= ss_d;
      done_q <= done_d;
    end
  end

  assign run     = (st_q != ST_IDLE);
  assign sck     = sck_q;
  assign mosi    = tx_q[DATA_W-1];
  assign ss_n    = ss_q;
  assign rx_byte = out_q;
  assign rx_done = done_q;
endmodule

// File: rtl/spi_freeze_master.sv
module spi_freeze_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_ssoe,
  input  logic              cfg_wait_dis,
  input  logic              stop_req,
  input  logic              wait_req,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy,
  output logic              frozen,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_done
);
  logic rs_meta, rs_sync;
  logic ce, tick, accept, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  spi_pm_gate u_gate (
    .stop_req (stop_req),
    .wait_req (wait_req),
    .wait_dis (cfg_wait_dis),
    .ce       (ce)
  );

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rs_sync),
    .ce     (ce),
    .run    (run),
    .load   (accept),
    .div_in (cfg_div),
    .tick   (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rs_sync),
    .ce      (ce),
    .tick    (tick),
    .start   (start),
    .tx_byte (tx_byte),
    .ssoe    (cfg_ssoe),
    .miso    (miso),
    .accept  (accept),
    .run     (run),
    .sck     (sck),
    .mosi    (mosi),
    .ss_n    (ss_n),
    .rx_byte (rx_byte),
    .rx_done (rx_done)
  );

  assign busy   = run;
  assign frozen = run & ~ce;
endmodule

// File: rtl/spi_freeze_master_chk.sv
module spi_freeze_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cfg_ssoe,
  input logic cfg_wait_dis,
  input logic stop_req,
  input logic wait_req,
  input logic sck,
  input logic mosi,
  input logic ss_n,
  input logic busy,
  input logic rx_done
);
  logic hold_in;
  assign hold_in = stop_req | (wait_req & cfg_wait_dis);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R1
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mosi)) |-> $fell(sck)); // R1
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold_in) |=> ($stable(sck) && $stable(mosi) && $stable(ss_n) && busy)); // R3
  AST_STOP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_req) |=> $stable(sck)); // R5
  AST_SS_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ssoe && $rose(sck)) |-> !ss_n); // R7
  AST_SS_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ssoe |-> ss_n); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R9
  AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> busy); // R10
  AST_START_FROZEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold_in && start) |=> !busy); // R10
endmodule

bind spi_freeze_master spi_freeze_master_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .cfg_ssoe     (cfg_ssoe),
  .cfg_wait_dis (cfg_wait_dis),
  .stop_req     (stop_req),
  .wait_req     (wait_req),
  .sck          (sck),
  .mosi         (mosi),
  .ss_n         (ss_n),
  .busy         (busy),
  .rx_done      (rx_done)
);

// File: tb/spi_freeze_master_test.sv
module spi_freeze_master_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk, rst_n, start;
  logic [7:0] tx_byte, cfg_div, rx_byte;
  logic       cfg_ssoe, cfg_wait_dis, stop_req, wait_req, miso;
  logic       sck, mosi, ss_n, busy, frozen, rx_done;

  int n_chk, n_fail;
  int cnt, done_cnt, cur_div;
  bit first_edge, last_sck;
  logic [7:0] slv, srx, exp_rx;

  spi_freeze_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
    .cfg_div(cfg_div), .cfg_ssoe(cfg_ssoe), .cfg_wait_dis(cfg_wait_dis),
    .stop_req(stop_req), .wait_req(wait_req), .miso(miso),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .busy(busy), .frozen(frozen),
    .rx_byte(rx_byte), .rx_done(rx_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ce_b();
    return !(stop_req || (wait_req && cfg_wait_dis));
  endfunction

  // slave model: sample MOSI on rise, present next bit after fall
  always @(posedge sck) srx = {srx[6:0], mosi};
  always @(negedge sck) begin
    slv  = {slv[6:0], 1'b0};
    miso = slv[7];
  end

  // monitor: half-period length in enabled cycles (R2, R4), done pulse (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck !== last_sck) begin
        if (!first_edge) chk(cnt == cur_div + 1, "R2/R4 half-period", cnt, cur_div + 1);
        else begin
          first_edge = 1'b0;
          chk(ss_n == !cfg_ssoe, "R7/R8 ss_n at first rise", ss_n, !cfg_ssoe);
        end
        cnt = 0;
        last_sck = sck;
      end
      if (busy && ce_b()) cnt++;
      if (rx_done) begin
        done_cnt++;
        chk(rx_byte == exp_rx, "R9/R6 rx_byte at done", rx_byte, exp_rx);
      end
    end
  end

  // hold_kind: 0 none, 1 stop, 2 wait
  task automatic xfer(input logic [7:0] mtx, input logic [7:0] stx, input int div,
                      input bit ssoe, input bit wdis, input int pm_rate,
                      input int hold_kind, input bit poke);
    int k;
    logic s0, m0, q0;
    stop_req = 0; wait_req = 0;
    cfg_div = 8'(div); cfg_ssoe = ssoe; cfg_wait_dis = wdis;
    cur_div = div; slv = stx; miso = stx[7]; exp_rx = stx;
    done_cnt = 0; first_edge = 1'b1;
    @(posedge clk) #1 start = 1; tx_byte = mtx;
    @(posedge clk) #1 start = 0;
    chk(busy == 1, "R10 start accepted when idle", busy, 1);
    k = 0;
    while (busy) begin
      if (poke && k == 3) begin
        start = 1; tx_byte = ~mtx;
      end else start = 0;
      if (hold_kind != 0 && k == 4 * (div + 1)) begin
        if (hold_kind == 1) stop_req = 1; else wait_req = 1;
        @(negedge clk); s0 = sck; m0 = mosi; q0 = ss_n;
        repeat (30) @(negedge clk);
        chk(sck == s0 && mosi == m0 && ss_n == q0 && busy,
            hold_kind == 1 ? "R3/R5 stop freeze" : "R3 wait freeze",
            {sck, mosi, ss_n, busy}, {s0, m0, q0, 1'b1});
        @(posedge clk) #1 stop_req = 0; wait_req = 0;
      end else if (pm_rate != 0) begin
        stop_req = ($urandom % 100) < pm_rate;
        wait_req = ($urandom % 100) < pm_rate;
      end
      k++;
      @(posedge clk) #1;
    end
    start = 0; stop_req = 0; wait_req = 0;
    @(negedge clk);
    chk(srx == mtx, "R6 slave received tx_byte", srx, mtx);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
    chk(sck == 0 && ss_n == 1, "R1/R7 idle pins after transfer", {sck, ss_n}, 2'b01);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cnt = 0; done_cnt = 0; cur_div = 0;
    first_edge = 1; last_sck = 0; srx = 0; slv = 0; exp_rx = 0;
    rst_n = 0; start = 0; tx_byte = 0; cfg_div = 0; cfg_ssoe = 0;
    cfg_wait_dis = 0; stop_req = 0; wait_req = 0; miso = 0;
    void'($urandom(32'h5a17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sck == 0 && mosi == 0 && ss_n == 1 && busy == 0 && rx_done == 0,
        "R11 reset state", {sck, mosi, ss_n, busy, rx_done}, 5'b00100);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // directed corners
    xfer(8'hA5, 8'h3C, 0, 1, 0, 0, 0, 0);
    xfer(8'hFF, 8'h00, 3, 1, 0, 0, 1, 0);   // stop with wait_dis=0 (R5)
    xfer(8'h01, 8'h80, 2, 1, 1, 0, 2, 0);   // wait with wait_dis=1 (R3)
    xfer(8'h5A, 8'hC3, 1, 0, 0, 30, 0, 0);  // wait ignored, ssoe off (R4, R8)
    xfer(8'h96, 8'h69, 2, 1, 0, 0, 0, 1);   // start while busy (R10)

    // start while frozen and idle is ignored (R10)
    @(posedge clk) #1 stop_req = 1; start = 1; tx_byte = 8'h77;
    @(posedge clk) #1 start = 0;
    repeat (3) @(posedge clk);
    #1 chk(busy == 0 && sck == 0, "R10 start ignored when frozen", busy, 0);
    stop_req = 0;

    for (int i = 0; i < 40; i++) begin
      xfer(8'($urandom), 8'($urandom), $urandom % 4, 1'($urandom), 1'($urandom),
           $urandom % 40, 0, (i % 7) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule